// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block is one DMA channel that moves data between memory and a single fixed peripheral port. It holds two transfer descriptors, A and B, each made of a start address and a byte count. A buffer-select flag records which descriptor is active. Software can load and arm one descriptor while the channel is still working through the other. When the active descriptor runs out, the channel flags it done, flips the buffer-select flag and carries straight on with the other descriptor if that one is armed.

Software controls the channel through an 8-bit control/status word. It has no plain write port. A set mask turns bits on and a clear mask turns bits off, with a 1 in a mask bit acting on the matching status bit and an all-zero mask doing nothing. A separate read port returns the word. A 32-bit device configuration register selects the transfer direction, the byte order, the burst length, the datum width, a device select code and the peripheral port address. These settings appear on dedicated outputs.

Each pulse on the device request input that arrives while the active descriptor is armed starts one burst on a request/grant memory interface. The active descriptor then advances by the number of bytes moved. A fault reported with the grant stops the channel and raises the error flag.

Top module: `pp_dma_channel`

## Requirements
- R1: After reset the status word reads 0, `irq` is 0, the configuration register reads 0, `memReq` is 0, and both descriptors read address 0 and count 0.
- R2: Status bit map: [0] run, [1] interrupt enable, [2] error, [3] done A, [4] start A, [5] done B, [6] start B, [7] buffer select (0 = A active, 1 = B active). A 1 on the set mask turns on run, interrupt enable, start A or start B. A 1 on the set mask has no effect on error, done A, done B or buffer select. A 1 on the clear mask turns off any bit except buffer select, which software cannot change through either mask.
- R3: A start bit is accepted only if run is 1 after the same write. A start request made while run stays 0 leaves the start bit at 0.
- R4: In the idle state, a `devReq` cycle with run and the active start bit set, and a non-zero active count, raises `memReq` on the next cycle. `memReq` stays high, with `memAddr` and `memBytes` held, until `memGnt`. `memAddr` is the active descriptor's current address. `memBytes` is the smaller of the remaining count and the burst size. The burst size is (8 if config bit 2 is 1, else 4) times (2 if config bit 3 is 1, else 1).
- R5: A burst granted without a fault adds `memBytes` to the active address and subtracts it from the active count. A descriptor write aimed at the buffer whose burst is in flight is ignored.
- R6: When the active count reaches 0, the active start bit clears, the matching done bit sets and buffer select toggles. An armed descriptor whose count is already 0 completes this way without any memory request.
- R7: After a completion, the channel serves the other descriptor from the next `devReq` if that descriptor's start bit is set. If it is not set, `devReq` raises no `memReq`.
- R8: `irq` is 1 exactly when interrupt enable is 1 and at least one of done A, done B or error is 1.
- R9: `memErr` together with `memGnt` sets error and clears run. It leaves the descriptor unchanged.
- R10: Clearing run during a burst lets that burst finish. After that, `devReq` raises no request, and the descriptors and the done bits keep their values.
- R11: The configuration register reads back as written. Bit 0 drives `memWrite` (1 = device to memory), bit 1 drives `memBigEnd`, bit 3 drives `memWide`, bits [7:4] drive `devSel` and bits [31:8] drive `devPort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrSetMask | input | 8 | Bits to turn on in the status word |
| csrClrMask | input | 8 | Bits to turn off in the status word |
| csrRdData | output | 8 | Status word read port |
| irq | output | 1 | Interrupt request |
| descWe | input | 1 | Descriptor write strobe |
| descSel | input | 1 | Descriptor to write (0 = A, 1 = B) |
| descAddr | input | ADDR_W | Start address to load |
| descCnt | input | CNT_W | Byte count to load |
| descRdSel | input | 1 | Descriptor to read back |
| descRdAddr | output | ADDR_W | Current address of the selected descriptor |
| descRdCnt | output | CNT_W | Remaining count of the selected descriptor |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 32 | Configuration write value |
| cfgRdData | output | 32 | Configuration read port |
| devReq | input | 1 | Peripheral asks for one burst |
| memReq | output | 1 | Burst request to memory |
| memAddr | output | ADDR_W | Burst start address |
| memBytes | output | 5 | Bytes in this burst |
| memWrite | output | 1 | Direction: 1 writes memory from the device |
| memBigEnd | output | 1 | Big-endian byte order |
| memWide | output | 1 | Two-byte datum |
| devSel | output | 4 | Device select code |
| devPort | output | 24 | Peripheral port address |
| memGnt | input | 1 | Memory accepts the burst |
| memErr | input | 1 | Fault reported with the grant |

## Verification
A wrong buffer-select value shows up at once. The next `memAddr` comes from the wrong descriptor, and the status word shows the wrong done bit on the cycle after completion. A count that decrements wrongly shows up as a wrong `memBytes` or a wrong number of bursts before the done bit appears, which can take a few bursts. The descriptor readback port confirms it directly. Run, error and interrupt-enable faults appear on `irq` and on the next `devReq`, where a request is raised or withheld one cycle later.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int CSR_W    = 8;
  localparam int RUN_B    = 0;
  localparam int IE_B     = 1;
  localparam int ERR_B    = 2;
  localparam int DONEA_B  = 3;
  localparam int STRTA_B  = 4;
  localparam int BIU_B    = 7;
  localparam int BYTES_W  = 5;
  localparam int CFG_W    = 32;
  localparam int CFG_DIR  = 0;
  localparam int CFG_BIG  = 1;
  localparam int CFG_B8   = 2;
  localparam int CFG_WIDE = 3;
  localparam int SEL_LO   = 4;
  localparam int SEL_W    = 4;
  localparam int PORT_LO  = 8;
  localparam int PORT_W   = 24;

  typedef struct packed {
    logic busy;
    logic step;
    logic sel;
  } dpCmd_t;

  typedef enum logic {ST_WAIT, ST_XFER} chState_e;
endpackage

// File: rtl/pp_dma_dp.sv
module pp_dma_dp
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                descWe,
  input  logic                descSel,
  input  logic [ADDR_W-1:0]   descAddr,
  input  logic [CNT_W-1:0]    descCnt,
  input  logic                descRdSel,
  output logic [ADDR_W-1:0]   descRdAddr,
  output logic [CNT_W-1:0]    descRdCnt,
  input  logic                cfgWe,
  input  logic [CFG_W-1:0]    cfgWdata,
  output logic [CFG_W-1:0]    cfgQ,
  input  dpCmd_t              cmd,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BYTES_W-1:0]  memBytes,
  output logic                actZero,
  output logic                actLast
);
  localparam int NBUF = 2;

  logic [ADDR_W-1:0]  addrQ [NBUF];
  logic [CNT_W-1:0]   cntQ  [NBUF];
  logic [BYTES_W-1:0] burstBytes;
  logic [CNT_W-1:0]   burstExt;
  logic [CNT_W-1:0]   actCnt;
  logic [BYTES_W-1:0] chunk;

  // Burst length in bytes: beats (4 or 8) times datum size (1 or 2)
  always_comb begin
    case ({cfgQ[CFG_WIDE], cfgQ[CFG_B8]})
      2'b00:   burstBytes = BYTES_W'(4);
      2'b01:   burstBytes = BYTES_W'(8);
      2'b10:   burstBytes = BYTES_W'(8);
      default: burstBytes = BYTES_W'(16);
    endcase
  end

  assign burstExt = CNT_W'(burstBytes);
  assign actCnt   = cntQ[cmd.sel];
  assign chunk    = (actCnt < burstExt) ? actCnt[BYTES_W-1:0] : burstBytes;
  assign actZero  = (actCnt == '0);
  assign actLast  = (actCnt <= burstExt);

  generate
    for (genvar g = 0; g < NBUF; g++) begin : gDesc
      logic [ADDR_W-1:0] addrR;
      logic [CNT_W-1:0]  cntR;
      logic              locked;
      assign locked = cmd.busy && (cmd.sel == 1'(g));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          addrR <= '0;
          cntR  <= '0;
        end else if (descWe && (descSel == 1'(g)) && !locked) begin
          addrR <= descAddr;
          cntR  <= descCnt;
        end else if (cmd.step && (cmd.sel == 1'(g))) begin
          addrR <= addrR + ADDR_W'(chunk);
          cntR  <= cntR - CNT_W'(chunk);
        end
      end
      assign addrQ[g] = addrR;
      assign cntQ[g]  = cntR;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)      cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgWdata;
  end

  assign memAddr    = addrQ[cmd.sel];
  assign memBytes   = chunk;
  assign descRdAddr = addrQ[descRdSel];
  assign descRdCnt  = cntQ[descRdSel];

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.busy && !cmd.step && !cfgWe) |=> $stable(memAddr)); // R4

  AST_CHUNK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.busy |-> (memBytes != '0 && memBytes <= burstBytes)); // R4

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step |=> (cntQ[$past(cmd.sel)] == $past(actCnt) - CNT_W'($past(chunk)))); // R5
endmodule

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
  import pp_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CSR_W-1:0] setMask,
  input  logic [CSR_W-1:0] clrMask,
  output logic [CSR_W-1:0] csrRd,
  output logic             irq,
  input  logic             devReq,
  input  logic             memGnt,
  input  logic             memErr,
  input  logic             actZero,
  input  logic             actLast,
  output logic             memReq,
  output dpCmd_t           cmd
);
  localparam int NBUF = 2;

  chState_e        stateQ, stateD;
  logic            runQ, runD;
  logic            ieQ, ieD;
  logic            errQ, errD;
  logic            biuQ, biuD;
  logic [NBUF-1:0] strtQ, strtD;
  logic [NBUF-1:0] doneQ, doneD;
  logic            evComplete;
  logic            evErr;
  logic            stepC;

  // Sequencing: start bursts, finish descriptors, catch faults
  always_comb begin
    stateD     = stateQ;
    evComplete = 1'b0;
    evErr      = 1'b0;
    stepC      = 1'b0;
    case (stateQ)
      ST_WAIT: begin
        if (runQ && strtQ[biuQ]) begin
          if (actZero)     evComplete = 1'b1;
          else if (devReq) stateD     = ST_XFER;
        end
      end
      default: begin
        if (memGnt) begin
          stateD = ST_WAIT;
          if (memErr) begin
            evErr = 1'b1;
          end else begin
            stepC = 1'b1;
            if (actLast) evComplete = 1'b1;
          end
        end
      end
    endcase
  end

  // Status word update: software masks merged with hardware events
  always_comb begin
    runD = (runQ | setMask[RUN_B]) & ~clrMask[RUN_B] & ~evErr;
    ieD  = (ieQ | setMask[IE_B]) & ~clrMask[IE_B];
    errD = (errQ & ~clrMask[ERR_B]) | evErr;
    biuD = biuQ ^ evComplete;
    for (int b = 0; b < NBUF; b++) begin
      doneD[b] = (doneQ[b] & ~clrMask[DONEA_B + 2*b])
               | (evComplete & (biuQ == 1'(b)));
      strtD[b] = (strtQ[b] & ~(evComplete & (biuQ == 1'(b)))
                           & ~clrMask[STRTA_B + 2*b])
               | (setMask[STRTA_B + 2*b] & runD);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_WAIT;
      runQ   <= 1'b0;
      ieQ    <= 1'b0;
      errQ   <= 1'b0;
      biuQ   <= 1'b0;
      strtQ  <= '0;
      doneQ  <= '0;
    end else begin
      stateQ <= stateD;
      runQ   <= runD;
      ieQ    <= ieD;
      errQ   <= errD;
      biuQ   <= biuD;
      strtQ  <= strtD;
      doneQ  <= doneD;
    end
  end

  always_comb begin
    csrRd              = '0;
    csrRd[RUN_B]       = runQ;
    csrRd[IE_B]        = ieQ;
    csrRd[ERR_B]       = errQ;
    csrRd[BIU_B]       = biuQ;
    for (int b = 0; b < NBUF; b++) begin
      csrRd[DONEA_B + 2*b] = doneQ[b];
      csrRd[STRTA_B + 2*b] = strtQ[b];
    end
  end

  assign irq      = ieQ & (|doneQ | errQ);
  assign memReq   = (stateQ == ST_XFER);
  assign cmd.busy = memReq;
  assign cmd.step = stepC;
  assign cmd.sel  = biuQ;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> memReq); // R4

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(runQ && strtQ[biuQ] && devReq)); // R7

  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt && memErr) |=> (errQ && !runQ)); // R9

  AST_BIU_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt && !memErr && actLast) |=> (biuQ != $past(biuQ))); // R6
endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CSR_W-1:0]    csrSetMask,
  input  logic [CSR_W-1:0]    csrClrMask,
  output logic [CSR_W-1:0]    csrRdData,
  output logic                irq,
  input  logic                descWe,
  input  logic                descSel,
  input  logic [ADDR_W-1:0]   descAddr,
  input  logic [CNT_W-1:0]    descCnt,
  input  logic                descRdSel,
  output logic [ADDR_W-1:0]   descRdAddr,
  output logic [CNT_W-1:0]    descRdCnt,
  input  logic                cfgWe,
  input  logic [CFG_W-1:0]    cfgWdata,
  output logic [CFG_W-1:0]    cfgRdData,
  input  logic                devReq,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BYTES_W-1:0]  memBytes,
  output logic                memWrite,
  output logic                memBigEnd,
  output logic                memWide,
  output logic [SEL_W-1:0]    devSel,
  output logic [PORT_W-1:0]   devPort,
  input  logic                memGnt,
  input  logic                memErr
);
  dpCmd_t           cmd;
  logic             actZero;
  logic             actLast;
  logic [CFG_W-1:0] cfgQ;

  pp_dma_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .setMask (csrSetMask),
    .clrMask (csrClrMask),
    .csrRd   (csrRdData),
    .irq     (irq),
    .devReq  (devReq),
    .memGnt  (memGnt),
    .memErr  (memErr),
    .actZero (actZero),
    .actLast (actLast),
    .memReq  (memReq),
    .cmd     (cmd)
  );

  pp_dma_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .descWe     (descWe),
    .descSel    (descSel),
    .descAddr   (descAddr),
    .descCnt    (descCnt),
    .descRdSel  (descRdSel),
    .descRdAddr (descRdAddr),
    .descRdCnt  (descRdCnt),
    .cfgWe      (cfgWe),
    .cfgWdata   (cfgWdata),
    .cfgQ       (cfgQ),
    .cmd        (cmd),
    .memAddr    (memAddr),
    .memBytes   (memBytes),
    .actZero    (actZero),
    .actLast    (actLast)
  );

  assign cfgRdData = cfgQ;
  assign memWrite  = cfgQ[CFG_DIR];
  assign memBigEnd = cfgQ[CFG_BIG];
  assign memWide   = cfgQ[CFG_WIDE];
  assign devSel    = cfgQ[SEL_LO +: SEL_W];
  assign devPort   = cfgQ[PORT_LO +: PORT_W];
endmodule

// File: tb/sim_pp_dma_channel.sv
`timescale 1ns/1ps
module sim_pp_dma_channel;
  localparam logic [7:0] C_RUN = 8'h01, C_IE = 8'h02, C_ERR = 8'h04, C_DA = 8'h08;
  localparam logic [7:0] C_SA = 8'h10, C_DB = 8'h20, C_SB = 8'h40, C_BIU = 8'h80;

  typedef struct packed {
    logic [3:0]  cfg;
    logic [15:0] cnt;
    logic [31:0] base;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{4'b0000, 16'd12, 32'h0000_1000},
    '{4'b0100, 16'd20, 32'h0000_2000},
    '{4'b1100, 16'd40, 32'h0000_3000},
    '{4'b1000, 16'd3,  32'h0000_4000},
    '{4'b0011, 16'd9,  32'h0000_5000},
    '{4'b0110, 16'd16, 32'h0000_6000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  csrSetMask = '0, csrClrMask = '0, csrRdData;
  logic        irq;
  logic        descWe = 1'b0, descSel = 1'b0, descRdSel = 1'b0;
  logic [31:0] descAddr = '0, descRdAddr;
  logic [15:0] descCnt = '0, descRdCnt;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0, cfgRdData;
  logic        devReq = 1'b0, memReq, memGnt = 1'b0, memErr = 1'b0;
  logic [31:0] memAddr;
  logic [4:0]  memBytes;
  logic        memWrite, memBigEnd, memWide;
  logic [3:0]  devSel;
  logic [23:0] devPort;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pp_dma_channel u0 (
    .clk(clk), .rstN(rstN), .csrSetMask(csrSetMask), .csrClrMask(csrClrMask),
    .csrRdData(csrRdData), .irq(irq), .descWe(descWe), .descSel(descSel),
    .descAddr(descAddr), .descCnt(descCnt), .descRdSel(descRdSel),
    .descRdAddr(descRdAddr), .descRdCnt(descRdCnt), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdData(cfgRdData), .devReq(devReq),
    .memReq(memReq), .memAddr(memAddr), .memBytes(memBytes),
    .memWrite(memWrite), .memBigEnd(memBigEnd), .memWide(memWide),
    .devSel(devSel), .devPort(devPort), .memGnt(memGnt), .memErr(memErr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic csrSet(input logic [7:0] m);
    @(negedge clk) csrSetMask = m;
    @(negedge clk) csrSetMask = '0;
  endtask

  task automatic csrClr(input logic [7:0] m);
    @(negedge clk) csrClrMask = m;
    @(negedge clk) csrClrMask = '0;
  endtask

  task automatic wrDesc(input logic s, input logic [31:0] a, input logic [15:0] c);
    @(negedge clk) begin descWe = 1'b1; descSel = s; descAddr = a; descCnt = c; end
    @(negedge clk) descWe = 1'b0;
  endtask

  task automatic wrCfg(input logic [31:0] v);
    @(negedge clk) begin cfgWe = 1'b1; cfgWdata = v; end
    @(negedge clk) cfgWe = 1'b0;
  endtask

  task automatic rdDesc(input logic s, output logic [31:0] a, output logic [15:0] c);
    descRdSel = s;
    #0.5;
    a = descRdAddr;
    c = descRdCnt;
  endtask

  task automatic pulseReq();
    @(negedge clk) devReq = 1'b1;
    @(negedge clk) devReq = 1'b0;
  endtask

  task automatic burst(input string tag, input logic [31:0] a, input int b);
    pulseReq();
    chk({tag, " memReq"}, 64'(memReq), 64'd1);
    chk({tag, " memAddr"}, 64'(memAddr), 64'(a));
    chk({tag, " memBytes"}, 64'(memBytes), 64'(b));
    memGnt = 1'b1;
    @(negedge clk) memGnt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] ra;
    logic [15:0] rc;
    logic        expBiu;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 csr", 64'(csrRdData), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 cfg", 64'(cfgRdData), 64'h0);
    chk("R1 memReq", 64'(memReq), 64'h0);
    rdDesc(1'b1, ra, rc);
    chk("R1 descB", {ra, 16'h0, rc}, 64'h0);

    // Vector table: R4 R5 R6 R7 R8 R11 across burst/width settings
    expBiu = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      int bb, rem;
      logic [31:0] a;
      logic [7:0] expCsr;
      bb  = (VECS[i].cfg[2] ? 8 : 4) * (VECS[i].cfg[3] ? 2 : 1);
      rem = int'(VECS[i].cnt);
      a   = VECS[i].base;
      wrCfg({24'h00C0DE + 24'(i), 4'(i), VECS[i].cfg});
      chk("R11 dir", 64'(memWrite), 64'(VECS[i].cfg[0]));
      chk("R11 endian", 64'(memBigEnd), 64'(VECS[i].cfg[1]));
      wrDesc(expBiu, a, VECS[i].cnt);
      csrSet(C_RUN | C_IE | (expBiu ? C_SB : C_SA));
      while (rem > 0) begin
        int b;
        b = (rem < bb) ? rem : bb;
        burst("R4 table", a, b);
        rem -= b;
        a   += 32'(b);
      end
      expCsr = C_RUN | C_IE | (expBiu ? C_DB : C_DA) | (expBiu ? 8'h00 : C_BIU);
      chk("R6 table csr", 64'(csrRdData), 64'(expCsr));
      chk("R8 table irq", 64'(irq), 64'd1);
      rdDesc(expBiu, ra, rc);
      chk("R5 table desc", {ra, 16'h0, rc}, {a, 16'h0, 16'h0});
      csrClr(C_DA | C_DB);
      chk("R8 irq cleared", 64'(irq), 64'd0);
      expBiu = ~expBiu;
    end

    // R2: set port ignored for error/done/select, clear ignored for select
    csrSet(C_ERR | C_DA | C_DB | C_BIU);
    chk("R2 set ignored", 64'(csrRdData), 64'(C_RUN | C_IE));
    chk("R2 irq quiet", 64'(irq), 64'd0);
    csrClr(C_BIU);
    chk("R2 clr biu ignored", 64'(csrRdData), 64'(C_RUN | C_IE));

    // R3: start refused without run
    csrClr(C_RUN);
    csrSet(C_SA);
    chk("R3 start refused", 64'(csrRdData), 64'(C_IE));

    // R6: zero-count descriptor A completes without a request
    csrSet(C_RUN | C_SA);
    chk("R3 start with run", 64'(csrRdData), 64'(C_RUN | C_IE | C_SA));
    chk("R6 no req", 64'(memReq), 64'd0);
    @(negedge clk);
    chk("R6 zero complete", 64'(csrRdData), 64'(C_RUN | C_IE | C_DA | C_BIU));
    chk("R6 zero no req", 64'(memReq), 64'd0);
    csrClr(C_DA);

    // R7: B not armed -> stall
    devReq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 stall", 64'(memReq), 64'd0);
    end
    devReq = 1'b0;

    // R7: both armed, B then A back to back
    wrCfg(32'h0);
    wrDesc(1'b1, 32'h8000, 16'd8);
    wrDesc(1'b0, 32'h9000, 16'd4);
    csrSet(C_SA | C_SB);
    burst("R7 B0", 32'h8000, 4);
    burst("R7 B1", 32'h8004, 4);
    chk("R7 switch to A", 64'(csrRdData), 64'(C_RUN | C_IE | C_SA | C_DB));
    burst("R7 A0", 32'h9000, 4);
    chk("R7 both done", 64'(csrRdData), 64'(C_RUN | C_IE | C_DA | C_DB | C_BIU));
    csrClr(C_IE);
    chk("R8 ie off", 64'(irq), 64'd0);
    csrSet(C_IE);
    chk("R8 ie on", 64'(irq), 64'd1);
    csrClr(C_DA | C_DB);

    // R4/R5: request held without grant, locked descriptor write ignored
    wrDesc(1'b1, 32'hA000, 16'd12);
    csrSet(C_SB);
    pulseReq();
    chk("R4 req up", 64'(memReq), 64'd1);
    wrDesc(1'b1, 32'hFFF0, 16'd99);
    chk("R4 req held", 64'(memReq), 64'd1);
    chk("R4 addr held", 64'(memAddr), 64'h0000_A000);
    @(negedge clk);
    chk("R4 bytes held", 64'(memBytes), 64'd4);
    memGnt = 1'b1;
    @(negedge clk) memGnt = 1'b0;
    rdDesc(1'b1, ra, rc);
    chk("R5 lock+advance", {ra, 16'h0, rc}, {32'h0000_A004, 16'h0, 16'd8});

    // R10: run cleared mid-burst
    pulseReq();
    chk("R10 addr", 64'(memAddr), 64'h0000_A004);
    csrClr(C_RUN);
    chk("R10 burst continues", 64'(memReq), 64'd1);
    memGnt = 1'b1;
    @(negedge clk) memGnt = 1'b0;
    rdDesc(1'b1, ra, rc);
    chk("R10 desc", {ra, 16'h0, rc}, {32'h0000_A008, 16'h0, 16'd4});
    chk("R10 csr", 64'(csrRdData), 64'(C_IE | C_SB | C_BIU));
    pulseReq();
    chk("R10 no req", 64'(memReq), 64'd0);

    // R9: fault with grant
    csrSet(C_RUN);
    burst("R9 fault", 32'h0000_A008, 4);
    memErr = 1'b0;
    chk("R9 csr", 64'(csrRdData), 64'(C_IE | C_ERR | C_SB | C_BIU));
    chk("R9 irq", 64'(irq), 64'd1);
    rdDesc(1'b1, ra, rc);
    chk("R9 desc kept", {ra, 16'h0, rc}, {32'h0000_A008, 16'h0, 16'd4});
    csrClr(C_ERR);
    chk("R9 err cleared", 64'(csrRdData), 64'(C_IE | C_SB | C_BIU));
    chk("R8 irq after clear", 64'(irq), 64'd0);

    // R11: configuration fields
    wrCfg(32'hABCDEF5B);
    chk("R11 readback", 64'(cfgRdData), 64'hABCDEF5B);
    chk("R11 fields", {memWrite, memBigEnd, memWide, devSel, devPort},
        {1'b1, 1'b1, 1'b1, 4'h5, 24'hABCDEF});

    done = 1'b1;
    summary();
  end

  // Fault injection on the R9 burst: memErr raised with the grant
  always @(negedge clk) if (memReq && memAddr == 32'h0000_A008 && csrRdData[0]) memErr = 1'b1;
endmodule